// File: doc/BRIEF.md
# Filter Sample FIFO with Sync Arming

This block buffers the words produced by a digital decimation filter so that software can collect them in batches instead of one at a time. Each data-ready strobe from the filter pushes the current sample word into a 16-entry, 32-bit first-in-first-out store. The reader pops words with a read strobe and always sees the oldest stored word on the head output. An interrupt line goes high once the number of stored words reaches a level chosen by a 4-bit configuration field.

An arming mode lets the capture start at a known instant. While armed and waiting, every data-ready strobe is discarded. The first synchronization pulse, for example one derived from a PWM timer, opens the gate. From then on every strobe is stored until the gate is re-armed or the store is flushed. A sticky overflow flag records any word lost because the store was full.

Top module: `sdf_sample_fifo`

## Requirements
- R1: After reset the count is 0, empty is 1, and full, overflow and interrupt are all 0.
- R2: Each accepted data-ready strobe stores the sample word. Each read strobe on a non-empty store removes the oldest word. The head output always shows the oldest stored word, so words leave in arrival order.
- R3: The count gives the number of stored words, from 0 to 16. Full is 1 exactly when the count is 16, and empty is 1 exactly when the count is 0.
- R4: A data-ready strobe into a full store with no read in the same cycle is dropped and sets the overflow flag. The flag stays set until a cycle with the clear input high and no new drop. If a drop and a clear fall in the same cycle, the flag stays set.
- R5: A read and an accepted write in the same cycle on a non-empty store leave the count unchanged. This also holds when the store is full, and the new word is stored behind the existing ones.
- R6: A read strobe on an empty store has no effect.
- R7: With the 4-bit level field L, the interrupt is 1 while the count is at least L+1. L=0 means one word and L=15 means sixteen.
- R8: With wait-for-sync enabled and no sync seen since the last arming, data-ready strobes are discarded. A sync pulse in the same cycle as a strobe lets that strobe through.
- R9: Once a sync has been seen, every following data-ready strobe is stored, with no further sync needed.
- R10: A re-arm pulse or a flush clears the sync-seen state, so the gate waits for a new sync.
- R11: A flush empties the store in one clock, and a strobe in the same cycle is discarded. The flush leaves the level field and the overflow flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | 32 | Filter output word |
| sample_rdy_i | input | 1 | Data-ready strobe from the filter |
| sync_pulse_i | input | 1 | External synchronization pulse |
| pop_i | input | 1 | Read strobe, removes the head word |
| flush_i | input | 1 | Empties the store in one clock |
| wait_sync_en_i | input | 1 | Enables wait-for-sync gating |
| rearm_i | input | 1 | Re-arms the sync gate |
| irq_level_i | input | 4 | Interrupt level L, fires at L+1 words |
| ovf_clr_i | input | 1 | Write-one-to-clear for the overflow flag |
| head_o | output | 32 | Oldest stored word |
| count_o | output | 5 | Number of stored words |
| empty_o | output | 1 | Store is empty |
| full_o | output | 1 | Store is full |
| ovf_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Fill-level interrupt |

## Verification
On every cycle the assertions check the following:
- the count never exceeds the depth;
- a flush clears the count;
- a read on an empty store and a balanced read-write pair leave the count alone;
- a blocked strobe never raises the count while the gate is closed;
- a drop into a full store sets the overflow flag, and the flag holds until it is cleared;
- a full store always drives the interrupt.

Only the bench scenarios can show data ordering across pointer wrap and the exact interrupt threshold for a given level. They also cover the re-arm sequence, where the gate must stay shut until a fresh sync arrives after having been open, and the case where a sync and a strobe fall in the same cycle.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  localparam int unsigned SF_DATA_W = 32;
  localparam int unsigned SF_DEPTH  = 16;
endpackage

// File: rtl/sfifo_sync_gate.sv
module sfifo_sync_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_en,
  input  logic sync_pulse,
  input  logic rearm,
  input  logic flush,
  input  logic sample_rdy,
  output logic wr_req,
  output logic seen
);
  logic seen_q, seen_d, sync_ok;

  always_comb begin
    seen_d = seen_q;
    if (rearm || flush)  seen_d = 1'b0;
    else if (sync_pulse) seen_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= seen_d;
  end

  // R8: a sync in the strobe's own cycle opens the gate for it
  assign sync_ok = (seen_q || sync_pulse) && !rearm && !flush;
  assign wr_req  = sample_rdy && (!wait_en || sync_ok);
  assign seen    = seen_q;
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  input  logic              flush,
  output logic [DATA_W-1:0] head,
  output logic [CW-1:0]     count,
  output logic              full,
  output logic              empty,
  output logic              wr_drop
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic rd_ok, wr_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign rd_ok   = rd_req && !empty && !flush;
  assign wr_ok   = wr_req && !flush && (!full || rd_ok);
  assign wr_drop = wr_req && !flush && full && !rd_req;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (wr_ok) wr_ptr_d = ptr_inc(wr_ptr_q);
      if (rd_ok) rd_ptr_d = ptr_inc(rd_ptr_q);
      case ({wr_ok, rd_ok})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr_q] <= wr_data;
  end

  assign head  = mem[rd_ptr_q];
  assign count = cnt_q;

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0));
  a_r6_pop_empty_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_req && !wr_req) |=> $stable(cnt_q));
  a_r5_balanced_rw: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && rd_req && wr_req && !flush) |=> $stable(cnt_q));
endmodule

// File: rtl/sfifo_flags.sv
module sfifo_flags #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_drop,
  input  logic          ovf_clr,
  input  logic [CW-1:0] count,
  input  logic [AW-1:0] level,
  output logic          ovf,
  output logic          irq
);
  logic ovf_q, ovf_d;

  always_comb begin
    ovf_d = ovf_q;
    if (wr_drop)      ovf_d = 1'b1;
    else if (ovf_clr) ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end

  assign ovf = ovf_q;
  assign irq = (count > {1'b0, level});

  a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q);
  a_r7_irq_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH)) |-> irq);
endmodule

// File: rtl/sdf_sample_fifo.sv
module sdf_sample_fifo #(
  parameter int unsigned DATA_W = sfifo_pkg::SF_DATA_W,
  parameter int unsigned DEPTH  = sfifo_pkg::SF_DEPTH,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              sample_rdy_i,
  input  logic              sync_pulse_i,
  input  logic              pop_i,
  input  logic              flush_i,
  input  logic              wait_sync_en_i,
  input  logic              rearm_i,
  input  logic [AW-1:0]     irq_level_i,
  input  logic              ovf_clr_i,
  output logic [DATA_W-1:0] head_o,
  output logic [CW-1:0]     count_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              ovf_o,
  output logic              irq_o
);
  logic wr_req, wr_drop, sync_seen;

  sfifo_sync_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .wait_en    (wait_sync_en_i),
    .sync_pulse (sync_pulse_i),
    .rearm      (rearm_i),
    .flush      (flush_i),
    .sample_rdy (sample_rdy_i),
    .wr_req     (wr_req),
    .seen       (sync_seen)
  );

  sfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_req  (wr_req),
    .wr_data (sample_i),
    .rd_req  (pop_i),
    .flush   (flush_i),
    .head    (head_o),
    .count   (count_o),
    .full    (full_o),
    .empty   (empty_o),
    .wr_drop (wr_drop)
  );

  sfifo_flags #(.DEPTH(DEPTH)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_drop (wr_drop),
    .ovf_clr (ovf_clr_i),
    .count   (count_o),
    .level   (irq_level_i),
    .ovf     (ovf_o),
    .irq     (irq_o)
  );

  a_r8_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_sync_en_i && !sync_seen && !sync_pulse_i) |=> (count_o <= $past(count_o)));
  a_r4_drop_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && sample_rdy_i && !pop_i && !flush_i && (!wait_sync_en_i || sync_seen)) |=> ovf_o);
endmodule

// File: tb/sdf_sample_fifo_bench.sv
`timescale 1ns/1ps
module sdf_sample_fifo_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] sample;
  logic        rdy, sync, pop, flush, wait_en, rearm, clr;
  logic [3:0]  lvl;
  logic [31:0] head;
  logic [4:0]  count;
  logic        empty, full, ovf, irq;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  sdf_sample_fifo u_sdf_sample_fifo (
    .clk(clk), .rst_n(rst_n), .sample_i(sample), .sample_rdy_i(rdy),
    .sync_pulse_i(sync), .pop_i(pop), .flush_i(flush),
    .wait_sync_en_i(wait_en), .rearm_i(rearm), .irq_level_i(lvl),
    .ovf_clr_i(clr), .head_o(head), .count_o(count), .empty_o(empty),
    .full_o(full), .ovf_o(ovf), .irq_o(irq)
  );

  typedef struct packed {
    logic        vld;
    logic        rd;
    logic [31:0] data;
    logic [4:0]  cnt;
    logic        irq;
    logic [31:0] head;
  } vec_t;

  // level 3: interrupt at four words, wait-for-sync off
  localparam vec_t TBL [12] = '{
    '{1'b1, 1'b0, 32'hA1, 5'd1, 1'b0, 32'hA1},
    '{1'b1, 1'b0, 32'hA2, 5'd2, 1'b0, 32'hA1},
    '{1'b1, 1'b0, 32'hA3, 5'd3, 1'b0, 32'hA1},
    '{1'b1, 1'b0, 32'hA4, 5'd4, 1'b1, 32'hA1},
    '{1'b1, 1'b1, 32'hA5, 5'd4, 1'b1, 32'hA2},
    '{1'b0, 1'b1, 32'h0,  5'd3, 1'b0, 32'hA3},
    '{1'b0, 1'b1, 32'h0,  5'd2, 1'b0, 32'hA4},
    '{1'b0, 1'b1, 32'h0,  5'd1, 1'b0, 32'hA5},
    '{1'b0, 1'b1, 32'h0,  5'd0, 1'b0, 32'h0},
    '{1'b0, 1'b1, 32'h0,  5'd0, 1'b0, 32'h0},
    '{1'b1, 1'b1, 32'hA6, 5'd1, 1'b0, 32'hA6},
    '{1'b0, 1'b1, 32'h0,  5'd0, 1'b0, 32'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // inputs set after a falling edge, outputs sampled at the next falling edge
  task automatic cyc(input logic v, input logic r, input logic s, input logic f,
                     input logic [31:0] d);
    rdy = v; pop = r; sync = s; flush = f; sample = d;
    @(posedge clk);
    @(negedge clk);
    rdy = 1'b0; pop = 1'b0; sync = 1'b0; flush = 1'b0; rearm = 1'b0; clr = 1'b0;
  endtask

  initial begin
    for (int n = 0; n < 100000; n++) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sample = '0; rdy = 0; sync = 0; pop = 0; flush = 0;
    wait_en = 0; rearm = 0; clr = 0; lvl = 4'd3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", 32'(count), 0);
    chk("R1 empty", 32'(empty), 1);
    chk("R1 full",  32'(full), 0);
    chk("R1 ovf",   32'(ovf), 0);
    chk("R1 irq",   32'(irq), 0);

    // table: R2 ordering, R3 flags, R5 balanced, R6 empty pop, R7 level
    for (int i = 0; i < 12; i++) begin
      cyc(TBL[i].vld, TBL[i].rd, 1'b0, 1'b0, TBL[i].data);
      chk("R3 count", 32'(count), 32'(TBL[i].cnt));
      chk("R3 empty", 32'(empty), 32'(TBL[i].cnt == 0));
      chk("R7 irq",   32'(irq), 32'(TBL[i].irq));
      if (TBL[i].cnt != 0) chk("R2 head", head, TBL[i].head);
    end

    // fill to sixteen with level 15
    lvl = 4'd15;
    for (int i = 0; i < 16; i++) begin
      cyc(1'b1, 1'b0, 1'b0, 1'b0, 32'h100 + 32'(i));
      if (i == 14) chk("R7 irq below level", 32'(irq), 0);
    end
    chk("R3 full", 32'(full), 1);
    chk("R3 count16", 32'(count), 16);
    chk("R7 irq at level", 32'(irq), 1);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 32'hDEAD);
    chk("R4 drop count", 32'(count), 16);
    chk("R4 ovf set", 32'(ovf), 1);
    chk("R4 head kept", head, 32'h100);

    // R11 flush keeps ovf and level, drops same-cycle strobe
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 32'hBEEF);
    chk("R11 flush count", 32'(count), 0);
    chk("R11 flush empty", 32'(empty), 1);
    chk("R11 ovf kept", 32'(ovf), 1);
    clr = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 0);
    chk("R4 ovf cleared", 32'(ovf), 0);

    // refill, then drop and clear in the same cycle
    for (int i = 0; i < 16; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, 32'h200 + 32'(i));
    clr = 1'b1;
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 32'hBAD);
    chk("R4 set wins over clear", 32'(ovf), 1);
    clr = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 0);
    chk("R4 ovf cleared again", 32'(ovf), 0);

    // R5 read and write while full
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 32'h210);
    chk("R5 full rw count", 32'(count), 16);
    chk("R5 no ovf", 32'(ovf), 0);
    lvl = 4'd0;
    for (int i = 1; i <= 16; i++) begin
      chk("R2 wrap order", head, 32'h200 + 32'(i));
      cyc(1'b0, 1'b1, 1'b0, 1'b0, 0);
    end
    chk("R3 drained", 32'(empty), 1);
    chk("R7 level0 empty", 32'(irq), 0);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 32'h55);
    chk("R7 level0 one word", 32'(irq), 1);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 0);

    // wait-for-sync gating
    wait_en = 1'b1;
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 32'h301);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 32'h302);
    chk("R8 blocked before sync", 32'(count), 0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 0);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 32'h303);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 32'h304);
    chk("R9 open after sync", 32'(count), 2);
    chk("R9 head", head, 32'h303);
    rearm = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 0);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 32'h305);
    chk("R10 rearm closes gate", 32'(count), 2);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 32'h306);
    chk("R8 same-cycle sync", 32'(count), 3);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 0);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 32'h307);
    chk("R10 flush closes gate", 32'(count), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule